// File: doc/BRIEF.md
# Dynamic Segment Approximate Multiplier

This block multiplies two signed 8-bit operands and returns a 16-bit signed product that approximates the true result. It does not form the full 8x8 product. It takes each operand's magnitude and finds the highest set bit. It keeps a 4-bit window that starts at that bit and covers the three bits below it. The two windows are multiplied exactly. The small product is then scaled back up by a left shift equal to the sum of how far each window sat above bit 0. A sign stage negates the result when the operand signs differ.

Operands narrower than the window pass through untouched, so small values multiply exactly. Larger values lose only the low bits under each window, so the result never overshoots the true magnitude. A parameter selects whether the product leaves through a register stage or straight from the logic. The register stage uses an active-low asynchronous reset. The block is intended for datapaths that accept bounded error in exchange for a much smaller multiplier array.

Top module: `dsm_approx_mult`

## Requirements
- R1: While `rst_n` is low, and with `REG_OUT`=1, `product` is 0 whatever the operands are.
- R2: Each operand's magnitude is its two's-complement absolute value. The operand -128 has magnitude 128, held as an unsigned 8-bit value.
- R3: Let L be the bit index of the highest 1 in a magnitude. If L >= 3, the segment is magnitude bits L down to L-3 and the shift is L-3. If L < 3, the segment is magnitude bits 3..0 and the shift is 0.
- R4: The product magnitude is (segment_a * segment_b) << (shift_a + shift_b). Every step is evaluated at 16 bits, so no bit is lost.
- R5: If either operand is 0, `product` is exactly 0.
- R6: The sign of the result comes from the two operand MSBs (bit 7). If the MSBs are equal (00 or 11), `product` equals the magnitude. If they differ (01 or 10), `product` is the two's-complement negation of the magnitude.
- R7: When both magnitudes are below 16, `product` equals the exact signed product.
- R8: The magnitude of `product` never exceeds |a|*|b|.
- R9: With `REG_OUT`=1, `product` shows the result for the operands present at the previous rising edge of `clk`. With `REG_OUT`=0 it follows the operands combinationally.
- R10: `product` is 16-bit two's complement. The largest magnitude is 16384, produced by -128 * -128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| opnd_a | input | 8 | First operand, two's complement |
| opnd_b | input | 8 | Second operand, two's complement |
| product | output | 16 | Approximate product, two's complement |

## Verification
The assertions assume two things. First, the operands are known values and never X. Second, with the register stage in place, the operands settle well before each rising edge. The latency and reset properties depend on this. The bench meets both conditions. It drives every operand pair only on the falling edge and releases reset on a falling edge. It sweeps all 65,536 pairs, including the -128 corner and zero operands. It also runs a few directed pairs aimed at the window and sign rules.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    // Pair of operand sign bits {a_msb, b_msb}
    typedef enum logic [1:0] {
        SGN_PP = 2'b00,
        SGN_PN = 2'b01,
        SGN_NP = 2'b10,
        SGN_NN = 2'b11
    } sign_pair_e;

endpackage

// File: rtl/dsm_seg_extract.sv
module dsm_seg_extract #(
    parameter int W   = 8,
    parameter int SEG = 4,
    parameter int SHW = 3
) (
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   mag,
    output logic [SEG-1:0] seg,
    output logic [SHW-1:0] shamt
);
    localparam int LW = $clog2(W);

    logic [LW-1:0] lead;

    // R2: two's-complement magnitude; -2^(W-1) maps to 2^(W-1) unsigned
    always_comb begin
        mag = opnd[W-1] ? (~opnd + 1'b1) : opnd;
    end

    // R3: leading-one index (highest set bit wins)
    always_comb begin
        lead = '0;
        for (int i = 0; i < W; i++) begin
            if (mag[i]) lead = i[LW-1:0];
        end
    end

    // R3: window at the leading one, or the raw low bits for small values
    always_comb begin
        if (int'(lead) >= SEG - 1) begin
            shamt = SHW'(int'(lead) - (SEG - 1));
            seg   = SEG'(mag >> shamt);
        end else begin
            shamt = '0;
            seg   = mag[SEG-1:0];
        end
    end

    always_comb begin
        if (mag >= W'(1 << (SEG - 1)))
            a_r3_window_msb: assert (seg[SEG-1])
                else $error("R3: window top bit clear for large magnitude");
        if (opnd != '0)
            a_r2_mag_nonzero: assert (mag != '0)
                else $error("R2: nonzero operand gave zero magnitude");
        a_r3_shift_range: assert (int'(shamt) <= W - SEG)
            else $error("R3: shift amount out of range");
    end

endmodule

// File: rtl/dsm_scale_sign.sv
module dsm_scale_sign
    import dsm_pkg::*;
#(
    parameter int W   = 8,
    parameter int SEG = 4,
    parameter int SHW = 3,
    parameter int PW  = 16
) (
    input  logic [SEG-1:0] seg_a,
    input  logic [SEG-1:0] seg_b,
    input  logic [SHW-1:0] sh_a,
    input  logic [SHW-1:0] sh_b,
    input  logic           sgn_a,
    input  logic           sgn_b,
    output logic [PW-1:0]  prod
);
    localparam int SUMW = SHW + 1;
    localparam int SPW  = 2 * SEG;

    logic [SPW-1:0]  small_p;
    logic [SUMW-1:0] sh_sum;
    logic [PW-1:0]   wide_p;
    logic [PW-1:0]   mag_p;
    sign_pair_e      sp;

    // R4: exact window product, widened to PW before shifting
    always_comb begin
        small_p = {{SEG{1'b0}}, seg_a} * {{SEG{1'b0}}, seg_b};
        sh_sum  = {1'b0, sh_a} + {1'b0, sh_b};
        wide_p  = {{(PW - SPW){1'b0}}, small_p};
        mag_p   = wide_p << sh_sum;
    end

    // R6: sign selection by operand MSB pair, mux only
    always_comb begin
        sp   = sign_pair_e'({sgn_a, sgn_b});
        prod = mag_p;
        unique case (sp)
            SGN_PP, SGN_NN: prod = mag_p;
            SGN_PN, SGN_NP: prod = ~mag_p + 1'b1;
        endcase
    end

    always_comb begin
        if (seg_a == '0 || seg_b == '0)
            a_r5_zero_out: assert (prod == '0)
                else $error("R5: zero window gave nonzero product");
        if (prod != '0)
            a_r6_sign_match: assert (prod[PW-1] == (sgn_a ^ sgn_b))
                else $error("R6: product sign mismatch");
    end

endmodule

// File: rtl/dsm_approx_mult.sv
module dsm_approx_mult #(
    parameter int W       = 8,
    parameter int SEG     = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [2*W-1:0]   product
);
    localparam int PW  = 2 * W;
    localparam int SHW = $clog2(W - SEG + 1);

    logic [W-1:0]   opnd_v [2];
    logic [W-1:0]   mag_v  [2];
    logic [SEG-1:0] seg_v  [2];
    logic [SHW-1:0] sh_v   [2];
    logic [PW-1:0]  comb_p;

    assign opnd_v[0] = opnd_a;
    assign opnd_v[1] = opnd_b;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        dsm_seg_extract #(.W(W), .SEG(SEG), .SHW(SHW)) u_seg (
            .opnd  (opnd_v[k]),
            .mag   (mag_v[k]),
            .seg   (seg_v[k]),
            .shamt (sh_v[k])
        );
    end

    dsm_scale_sign #(.W(W), .SEG(SEG), .SHW(SHW), .PW(PW)) u_scale (
        .seg_a (seg_v[0]),
        .seg_b (seg_v[1]),
        .sh_a  (sh_v[0]),
        .sh_b  (sh_v[1]),
        .sgn_a (opnd_a[W-1]),
        .sgn_b (opnd_b[W-1]),
        .prod  (comb_p)
    );

    // R9: optional output register
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) product <= '0;
            else        product <= comb_p;
        end

        a_r1_reset_zero: assert property (@(posedge clk)
            !rst_n |-> product == '0)
            else $error("R1: output not zero in reset");

        a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product == $past(comb_p))
            else $error("R9: registered output lags wrongly");
    end else begin : g_comb
        assign product = comb_p;
    end

    // R7 / R8: relate the product to the true operand magnitudes
    logic [PW-1:0] res_mag;
    logic [PW-1:0] exact_mag;
    always_comb begin
        res_mag   = comb_p[PW-1] ? (~comb_p + 1'b1) : comb_p;
        exact_mag = PW'(mag_v[0]) * PW'(mag_v[1]);
        a_r8_bound: assert (res_mag <= exact_mag)
            else $error("R8: approximation exceeds exact magnitude");
        if (mag_v[0] < W'(1 << SEG) && mag_v[1] < W'(1 << SEG))
            a_r7_small_exact: assert (res_mag == exact_mag)
                else $error("R7: small operands not exact");
    end

endmodule

// File: tb/tb_dsm_approx_mult.sv
module tb_dsm_approx_mult;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opa = '0;
    logic [7:0]  opb = '0;
    logic [15:0] product;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic signed [7:0]  a;
        logic signed [7:0]  b;
        logic signed [15:0] exp;
        int                 exact;
        string              tag;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    dsm_approx_mult #(.W(8), .SEG(4), .REG_OUT(1'b1)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .opnd_a  (opa),
        .opnd_b  (opb),
        .product (product)
    );

    // Independent model of R2..R6 and R10
    function automatic int mag_of(input logic signed [7:0] x);
        return (x < 0) ? -int'(x) : int'(x);
    endfunction

    function automatic int win_of(input int m, output int sh);
        int l = -1;
        for (int i = 0; i < 8; i++) if (((m >> i) & 1) == 1) l = i;
        if (l >= 3) begin
            sh = l - 3;
            return m >> sh;
        end
        sh = 0;
        return m;
    endfunction

    function automatic logic signed [15:0] model(input logic signed [7:0] x,
                                                 input logic signed [7:0] y);
        int sx, sy, wx, wy, m;
        wx = win_of(mag_of(x), sx);
        wy = win_of(mag_of(y), sy);
        m  = (wx * wy) << (sx + sy);
        return ((x < 0) != (y < 0)) ? 16'(-m) : 16'(m);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic signed [7:0] a, input logic signed [7:0] b,
                         input string tag);
        item_t it;
        @(negedge clk);
        opa = a;
        opb = b;
        it.a = a; it.b = b;
        it.exp = model(a, b);
        it.exact = mag_of(a) * mag_of(b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: R9 latency is implied by popping one edge after the push
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                int got, gmag;
                it   = sb_q.pop_front();
                got  = int'($signed(product));
                gmag = (got < 0) ? -got : got;
                check(got == int'(it.exp), it.tag, got, int'(it.exp));
                check(gmag <= it.exact, "R8 bound", gmag, it.exact);
                if (got != 0)
                    check((got < 0) == ((it.a < 0) != (it.b < 0)), "R6 sign",
                          got, int'(it.exp));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset holds output at zero with live operands
        opa = 8'd100;
        opb = 8'sd77;
        repeat (3) @(posedge clk);
        #1;
        check(product == 16'd0, "R1 reset", int'(product), 0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(-8'sd128, -8'sd128, "R10 max");   // 8*8<<8 = 16384
        drive(-8'sd128, 8'sd1, "R2 min operand"); // -128
        drive(8'sd91, 8'sd3, "R3 window");       // 11*3<<3 = 264
        drive(8'sd0, -8'sd77, "R5 zero");
        drive(-8'sd5, 8'sd7, "R6 neg");          // -35
        drive(8'sd12, -8'sd13, "R7 small");      // -156
        drive(8'sd127, 8'sd127, "R9 latency");   // 15*15<<6 = 14400

        // R4 exhaustive sweep; tag by class
        for (int i = 0; i < 65536; i++) begin
            logic signed [7:0] a, b;
            string tg;
            a = i[15:8];
            b = i[7:0];
            if (a == 0 || b == 0) tg = "R5 zero";
            else if (mag_of(a) < 16 && mag_of(b) < 16) tg = "R7 exact";
            else tg = "R4 product";
            drive(a, b, tg);
        end

        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule